// File: doc/BRIEF.md
# Flash Status Polling Engine

This block sits on the host side of a parallel NOR flash bus. After software or a command sequencer has issued a program or erase command, a one-cycle `start` launches the engine. The engine then performs repeated read cycles at a latched address and decides from the returned status bits whether the embedded operation has finished, failed or is still running. It does not use a ready/busy line. The decision comes from the status word itself, either by comparing the toggle bit across successive reads or by checking the data-polling bit against the value that was written.

Each read cycle is timed by small counters. The pulsed strobe, which is either output enable or chip select, is held high for at least `GAP_CYC` cycles before it falls. This gives the address setup and the minimum high time that status polling needs. The strobe is then held low for `ACC_CYC` cycles, and the status word is captured on the last low cycle. A third mode issues exactly two reads and reports whether bit 2 changed between them, which tells a sector under erase suspend apart from any other sector. Every run ends with exactly one of three single-cycle outcome pulses: done, fail or timeout. All controls are plain level or pulse signals; no streaming interface is involved.

Top module: `flash_status_poller`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `flash_cs_n` and `flash_oe_n` are high, and `busy`, `done`, `fail` and `timeout` are low.
- R2: Within a run, each read holds the pulsed strobe high for at least `GAP_CYC` cycles before it falls. It then keeps the strobe low for exactly `ACC_CYC` cycles and samples `flash_dq` on the last low cycle.
- R3: `pulse_cs`=0 pulses `flash_oe_n` and holds `flash_cs_n` low for the whole run. `pulse_cs`=1 pulses `flash_cs_n` and holds `flash_oe_n` low for the whole run.
- R4: Toggle mode (`mode` 01 or 11) ends with `done` on the first read whose bit 6 equals bit 6 of the read just before it.
- R5: In toggle mode, a read whose bit 6 differs from the previous read while its bit 5 is 1 starts a fresh pair of reads. If bit 6 matches within that pair, the result is `done`; if it differs, the result is `fail`.
- R6: Data-polling mode (`mode` 00) ends with `done` on the first read whose bit 7 equals `exp_bit7`.
- R7: In data-polling mode, a read with the wrong bit 7 and bit 5 equal to 1 causes exactly one more read. If that read has the right bit 7, the result is `done`; otherwise the result is `fail`.
- R8: Suspend-query mode (`mode` 10) makes exactly two reads, then pulses `done` with `sect_susp` set to the XOR of bit 2 from the two reads. `sect_susp` holds that value until the next start.
- R9: When the count of reads in a run reaches `max_polls` (latched at start; 0 acts as 1) without a decision, `timeout` pulses. A done or fail decision on that same read takes precedence over the timeout.
- R10: Each run ends with exactly one single-cycle pulse of `done`, `fail` or `timeout`, and the engine returns to idle with both strobes high. No further read cycle occurs until the next `start`, and a `start` that arrives while `busy` is high has no effect.
- R11: `flash_addr` carries the `target_addr` latched at start, and it does not change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch of a polling run |
| mode | input | 2 | 00 data polling, 01/11 toggle, 10 suspend query |
| pulse_cs | input | 1 | 1: pulse chip select between reads, 0: pulse output enable |
| exp_bit7 | input | 1 | Bit 7 of the data that was programmed |
| target_addr | input | AW | Address to poll |
| max_polls | input | CW | Read limit before timeout |
| flash_addr | output | AW | Bus address |
| flash_cs_n | output | 1 | Bus chip select, active low |
| flash_oe_n | output | 1 | Bus output enable, active low |
| flash_dq | input | DW | Bus read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Operation completed (pulse) |
| fail | output | 1 | Operation reported an error (pulse) |
| timeout | output | 1 | Read limit reached without decision (pulse) |
| sect_susp | output | 1 | Suspend-query result |

## Verification
The two functions that can coincide are the completion decision and the read-limit timeout. Both are judged on the same captured read. The bench provokes this with a toggle pattern whose bits settle on exactly the `max_polls`-th read, and with a data-polling pattern whose correct bit 7 first appears on the last permitted read. In both cases it expects `done` alone, with no `timeout`. The same read counter that the bench uses to judge the coincidence is also checked against runs whose status never settles, which must time out after exactly `max_polls` reads.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  // status bit positions inside the flash read word
  localparam int DPOLL_BIT = 7;
  localparam int TOG_BIT   = 6;
  localparam int TLIM_BIT  = 5;
  localparam int SUS_BIT   = 2;

  localparam logic [1:0] MODE_DATA  = 2'b00;
  localparam logic [1:0] MODE_QUERY = 2'b10;

  typedef struct packed {
    logic dpoll;
    logic tog;
    logic tlim;
    logic sus;
  } stat_t;

  typedef enum logic [1:0] {RD_IDLE, RD_GAP, RD_LOW} rd_phase_e;

  typedef enum logic [1:0] {VD_WAIT, VD_DONE, VD_FAIL, VD_RECHK} verdict_e;

  typedef enum logic {ST_IDLE, ST_POLL} run_state_e;

endpackage

// File: rtl/fpoll_rdcyc.sv
module fpoll_rdcyc
  import fpoll_pkg::*;
#(
  parameter int DW      = 16,
  parameter int GAP_CYC = 4,
  parameter int ACC_CYC = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          engaged,
  input  logic          pulse_cs,
  input  logic          req,
  input  logic [DW-1:0] din,
  output logic          cs_n,
  output logic          oe_n,
  output logic          smp_valid,
  output stat_t         smp_stat
);

  localparam int LONGEST = (GAP_CYC > ACC_CYC) ? GAP_CYC : ACC_CYC;
  localparam int TW      = $clog2(LONGEST + 1);

  rd_phase_e     ph;
  logic [TW-1:0] tcnt;
  stat_t         din_stat;
  logic          strobe_lo;
  logic          unused_dq;

  always_comb begin
    din_stat.dpoll = din[DPOLL_BIT];
    din_stat.tog   = din[TOG_BIT];
    din_stat.tlim  = din[TLIM_BIT];
    din_stat.sus   = din[SUS_BIT];
    unused_dq = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i != DPOLL_BIT && i != TOG_BIT && i != TLIM_BIT && i != SUS_BIT)
        unused_dq = unused_dq ^ din[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= RD_IDLE;
      tcnt      <= '0;
      smp_valid <= 1'b0;
      smp_stat  <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (!engaged && ph != RD_LOW) begin
        ph   <= RD_IDLE;
        tcnt <= '0;
      end else begin
        case (ph)
          RD_IDLE: if (req) begin
            ph   <= RD_GAP;
            tcnt <= '0;
          end
          RD_GAP: if (tcnt == TW'(GAP_CYC - 1)) begin
            ph   <= RD_LOW;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          RD_LOW: if (tcnt == TW'(ACC_CYC - 1)) begin
            ph        <= RD_IDLE;
            tcnt      <= '0;
            smp_valid <= 1'b1;
            smp_stat  <= din_stat;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          default: ph <= RD_IDLE;
        endcase
      end
    end
  end

  assign strobe_lo = (ph == RD_LOW);
  assign cs_n = !engaged | (pulse_cs & !strobe_lo);
  assign oe_n = !engaged | (!pulse_cs & !strobe_lo);

  // checker counters for strobe high/low run lengths
  logic [7:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (strobe_lo) begin
      hi_run <= '0;
      lo_run <= (lo_run == 8'hff) ? lo_run : lo_run + 1'b1;
    end else begin
      lo_run <= '0;
      hi_run <= (hi_run == 8'hff) ? hi_run : hi_run + 1'b1;
    end
  end

  p_gap_before_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_lo) |-> (int'(hi_run) >= GAP_CYC));

  p_low_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_lo) |-> (int'(lo_run) == ACC_CYC));

  p_sample_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(strobe_lo) && !strobe_lo);

endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge
  import fpoll_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       exp7,
  input  logic       have_prev,
  input  logic       confirm,
  input  stat_t      prev,
  input  stat_t      cur,
  output verdict_e   verdict,
  output logic       sus_diff
);

  logic unused_prev;
  assign unused_prev = prev.dpoll ^ prev.tlim;

  always_comb begin
    verdict  = VD_WAIT;
    sus_diff = prev.sus ^ cur.sus;
    if (mode == MODE_QUERY) begin
      if (have_prev) verdict = VD_DONE;
    end else if (mode == MODE_DATA) begin
      if (cur.dpoll == exp7)  verdict = VD_DONE;
      else if (confirm)       verdict = VD_FAIL;
      else if (cur.tlim)      verdict = VD_RECHK;
    end else begin
      if (have_prev) begin
        if (cur.tog == prev.tog) verdict = VD_DONE;
        else if (confirm)        verdict = VD_FAIL;
        else if (cur.tlim)       verdict = VD_RECHK;
      end
    end
  end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fpoll_pkg::*;
#(
  parameter int AW      = 21,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int GAP_CYC = 4,
  parameter int ACC_CYC = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          pulse_cs,
  input  logic          exp_bit7,
  input  logic [AW-1:0] target_addr,
  input  logic [CW-1:0] max_polls,
  output logic [AW-1:0] flash_addr,
  output logic          flash_cs_n,
  output logic          flash_oe_n,
  input  logic [DW-1:0] flash_dq,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout,
  output logic          sect_susp
);

  run_state_e    st;
  logic [1:0]    mode_q;
  logic          exp7_q, sel_q;
  logic [CW-1:0] max_q, cnt_q;
  logic [AW-1:0] addr_q;
  stat_t         prev_q;
  logic          have_prev_q, confirm_q;
  logic          done_q, fail_q, tmo_q, susp_q;

  logic          engaged, req, smp_valid, sus_diff;
  stat_t         smp_stat;
  verdict_e      verdict;
  logic [CW:0]   cnt_inc;

  assign engaged = (st == ST_POLL);
  assign req     = engaged && !smp_valid;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  fpoll_rdcyc #(.DW(DW), .GAP_CYC(GAP_CYC), .ACC_CYC(ACC_CYC)) u_rdcyc (
    .clk(clk), .rst_n(rst_n), .engaged(engaged), .pulse_cs(sel_q), .req(req),
    .din(flash_dq), .cs_n(flash_cs_n), .oe_n(flash_oe_n),
    .smp_valid(smp_valid), .smp_stat(smp_stat)
  );

  fpoll_judge u_judge (
    .mode(mode_q), .exp7(exp7_q), .have_prev(have_prev_q), .confirm(confirm_q),
    .prev(prev_q), .cur(smp_stat), .verdict(verdict), .sus_diff(sus_diff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      mode_q      <= MODE_DATA;
      exp7_q      <= 1'b0;
      sel_q       <= 1'b0;
      max_q       <= '0;
      cnt_q       <= '0;
      addr_q      <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      confirm_q   <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      tmo_q       <= 1'b0;
      susp_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st          <= ST_POLL;
          mode_q      <= mode;
          exp7_q      <= exp_bit7;
          sel_q       <= pulse_cs;
          max_q       <= (max_polls == '0) ? CW'(1) : max_polls;
          addr_q      <= target_addr;
          cnt_q       <= '0;
          have_prev_q <= 1'b0;
          confirm_q   <= 1'b0;
          susp_q      <= 1'b0;
        end
      end else if (smp_valid) begin
        cnt_q <= cnt_inc[CW-1:0];
        if (verdict == VD_DONE) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
          if (mode_q == MODE_QUERY) susp_q <= sus_diff;
        end else if (verdict == VD_FAIL) begin
          fail_q <= 1'b1;
          st     <= ST_IDLE;
        end else if (cnt_inc >= {1'b0, max_q}) begin
          tmo_q <= 1'b1;
          st    <= ST_IDLE;
        end else if (verdict == VD_RECHK) begin
          confirm_q   <= 1'b1;
          have_prev_q <= 1'b0;
        end else begin
          have_prev_q <= 1'b1;
          prev_q      <= smp_stat;
        end
      end
    end
  end

  assign flash_addr = addr_q;
  assign busy       = engaged;
  assign done       = done_q;
  assign fail       = fail_q;
  assign timeout    = tmo_q;
  assign sect_susp  = susp_q;

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, timeout}));

  p_outcome_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |=> !busy && !done && !fail && !timeout);

  p_idle_strobes_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> flash_cs_n && flash_oe_n);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(flash_addr));

  p_tmo_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cnt_q >= max_q));

  p_fail_after_recheck_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(confirm_q));

endmodule

// File: tb/flash_status_poller_tb.sv
`timescale 1ns/1ps
module flash_status_poller_tb;

  localparam int AW = 21, DW = 16, CW = 16, GAP = 4, ACC = 25;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sel;
    logic        e7;
    logic [15:0] maxp;
    logic [63:0] pat;   // read n returns byte n (byte 7 repeats)
    logic [1:0]  res;   // 0 done, 1 fail, 2 timeout
    logic [3:0]  nrd;
    logic        susp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 1'b0, 16'd20, 64'h0000000040400040, 2'd0, 4'd4, 1'b0},
    '{2'd1, 1'b1, 1'b0, 16'd20, 64'h0000000000000000, 2'd0, 4'd2, 1'b0},
    '{2'd1, 1'b0, 1'b0, 16'd20, 64'h0000000000006000, 2'd0, 4'd4, 1'b0},
    '{2'd3, 1'b1, 1'b0, 16'd20, 64'h0000000040006000, 2'd1, 4'd4, 1'b0},
    '{2'd1, 1'b0, 1'b0, 16'd5,  64'h4000400040004000, 2'd2, 4'd5, 1'b0},
    '{2'd1, 1'b1, 1'b0, 16'd3,  64'h0000000000404000, 2'd0, 4'd3, 1'b0},
    '{2'd0, 1'b0, 1'b1, 16'd20, 64'h0000000000800000, 2'd0, 4'd3, 1'b0},
    '{2'd0, 1'b1, 1'b0, 16'd20, 64'h0000000000000080, 2'd0, 4'd2, 1'b0},
    '{2'd0, 1'b0, 1'b1, 16'd20, 64'h0000000000008020, 2'd0, 4'd2, 1'b0},
    '{2'd0, 1'b0, 1'b1, 16'd20, 64'h0000000000000020, 2'd1, 4'd2, 1'b0},
    '{2'd0, 1'b1, 1'b1, 16'd4,  64'h0000000000000000, 2'd2, 4'd4, 1'b0},
    '{2'd2, 1'b0, 1'b0, 16'd20, 64'h0000000000000004, 2'd0, 4'd2, 1'b1},
    '{2'd2, 1'b1, 1'b0, 16'd20, 64'h0000000000000404, 2'd0, 4'd2, 1'b0},
    '{2'd0, 1'b1, 1'b0, 16'd2,  64'h0000000000000080, 2'd0, 4'd2, 1'b0}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:    return "R4";
      2, 3:    return "R5";
      4, 5:    return "R9";
      6, 7:    return "R6";
      8, 9:    return "R7";
      10, 13:  return "R9";
      default: return "R8";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic pulse_cs = 1'b0, exp_bit7 = 1'b0;
  logic [AW-1:0] target_addr = '0, flash_addr;
  logic [CW-1:0] max_polls = '0;
  logic flash_cs_n, flash_oe_n, busy, done, fail, timeout, sect_susp;
  logic [DW-1:0] flash_dq;

  always #2 clk = ~clk;

  flash_status_poller #(.AW(AW), .DW(DW), .CW(CW), .GAP_CYC(GAP), .ACC_CYC(ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pulse_cs(pulse_cs),
    .exp_bit7(exp_bit7), .target_addr(target_addr), .max_polls(max_polls),
    .flash_addr(flash_addr), .flash_cs_n(flash_cs_n), .flash_oe_n(flash_oe_n),
    .flash_dq(flash_dq), .busy(busy), .done(done), .fail(fail), .timeout(timeout),
    .sect_susp(sect_susp)
  );

  int n_chk = 0, n_fail = 0;
  int rd_idx = 0, base = 0;
  logic [63:0] cur_pat = '0;
  logic [AW-1:0] cur_addr = '0;
  logic cur_sel = 1'b0;
  int hi_run = 0, lo_run = 0, min_hi = 1000, bad_lo = 0, bad_other = 0, bad_addr = 0;
  logic prev_act = 1'b0;

  // flash model: status byte chosen by number of finished reads in this run
  always_comb begin
    int k;
    k = rd_idx - base;
    if (k > 7) k = 7;
    if (k < 0) k = 0;
    flash_dq = {8'h00, cur_pat[8*k +: 8]};
  end

  // bus monitor
  always @(negedge clk) begin
    logic act;
    act = !flash_cs_n && !flash_oe_n;
    if (prev_act && !act) begin
      rd_idx = rd_idx + 1;
      if (lo_run != ACC) bad_lo = bad_lo + 1;
    end
    if (!prev_act && act && hi_run < min_hi) min_hi = hi_run;
    if (act) begin
      lo_run = lo_run + 1; hi_run = 0;
      if (flash_addr != cur_addr) bad_addr = bad_addr + 1;
    end else begin
      hi_run = hi_run + 1; lo_run = 0;
    end
    if (busy && ((cur_sel && flash_oe_n) || (!cur_sel && flash_cs_n)))
      bad_other = bad_other + 1;
    prev_act = act;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int i, input bit poke);
    vec_t v;
    int res, n;
    v = VECS[i];
    @(negedge clk);
    base = rd_idx; cur_pat = v.pat; cur_sel = v.sel;
    cur_addr = AW'(21'h1000 + i);
    mode = v.mode; pulse_cs = v.sel; exp_bit7 = v.e7;
    max_polls = v.maxp; target_addr = cur_addr; start = 1'b1;
    @(negedge clk); start = 1'b0;
    res = 3; n = 0;
    while (n < 4000) begin
      @(negedge clk); n++;
      if (poke && n == 40) begin
        start = 1'b1; mode = 2'd2; target_addr = '1; max_polls = 16'd1;
      end else if (poke && n == 41) begin
        start = 1'b0;
      end
      if (done)    begin res = 0; break; end
      if (fail)    begin res = 1; break; end
      if (timeout) begin res = 2; break; end
    end
    chk(res == int'(v.res), poke ? "R10" : vtag(i), "outcome", res, int'(v.res));
    chk(rd_idx - base == int'(v.nrd), poke ? "R10" : vtag(i), "read count",
        rd_idx - base, int'(v.nrd));
    if (v.mode == 2'd2)
      chk(sect_susp == v.susp, "R8", "suspend flag", int'(sect_susp), int'(v.susp));
    @(negedge clk);
    chk(!done && !fail && !timeout && !busy, "R10", "single pulse then idle",
        int'({busy, done, fail, timeout}), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_cs_n && flash_oe_n && !busy && !done && !fail && !timeout, "R1",
        "in reset", int'({flash_cs_n, flash_oe_n, busy, done, fail, timeout}), 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flash_cs_n && flash_oe_n && !busy && !done && !fail && !timeout, "R1",
        "after reset", int'({flash_cs_n, flash_oe_n, busy, done, fail, timeout}), 6'b110000);

    for (int i = 0; i < NV; i++) run(i, 1'b0);

    // start while busy must not disturb a data-polling run (R10, R11)
    run(6, 1'b1);

    // engine stays off the bus after a run (R10)
    begin
      int r0;
      int quiet;
      r0 = rd_idx; quiet = 1;
      repeat (60) begin
        @(negedge clk);
        if (!flash_cs_n || !flash_oe_n || busy) quiet = 0;
      end
      chk(quiet == 1, "R10", "strobes high when idle", quiet, 1);
      chk(rd_idx == r0, "R10", "no reads after finish", rd_idx - r0, 0);
    end

    chk(min_hi >= GAP, "R2", "minimum strobe high cycles", min_hi, GAP);
    chk(bad_lo == 0, "R2", "strobe low width errors", bad_lo, 0);
    chk(bad_other == 0, "R3", "held strobe not low while busy", bad_other, 0);
    chk(bad_addr == 0, "R11", "address mismatch during reads", bad_addr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule